// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of the device end of a three-wire serial EEPROM. A host raises chip select and toggles a shift clock. On each rising edge of that clock the block samples the serial data input, and it answers on a single serial data output. The storage is a parameterized bit array, 4096 bits by default. A static strap input sets its organization. With the strap high the array is a set of 16-bit words; with the strap low it is a set of bytes. The strap also changes the address length.

Four instructions are decoded: read, write, enable writes and disable writes. A read starts from any address and keeps streaming later locations for as long as the host keeps clocking. A write replaces the addressed word in one step, with no erase step first. The block then goes busy for a programmable number of system clocks, which stands in for the self-timed programming interval. While chip select is high after a write, the data output reports busy or ready.

The block runs on a system clock and detects edges on the shift clock and on chip select. The host must hold the shift clock at each level for at least one system clock. The serial pins carry no valid/ready pair. Every bit is paced by the host's shift clock and the device never stalls a transfer. The only back-pressure is the busy status: a new instruction sent while a write is in progress is ignored, so the host must poll the data output until it reads ready.

Top module: `eep_serial_dev`

## Requirements
- R1: While chip select is low, the data output is 1 and any partly received instruction is discarded.
- R2: An instruction begins at the first rising shift-clock edge that samples a 1; earlier 0 bits are ignored. The 1 is followed by a 2-bit opcode and then the address, both MSB first. The address is 9 bits in byte mode and 8 bits in word mode for the default 4096-bit array.
- R3: After reset the array holds all zeros and writes are disabled. Opcode 00 with the two top address bits 11 enables writes; opcode 00 with the two top address bits 00 disables them.
- R4: A write received while writes are disabled leaves the array unchanged and does not start the busy interval.
- R5: Opcode 01 is followed by one data word, MSB first. At the shift edge that samples its last bit, the addressed word is overwritten directly.
- R6: Opcode 10 drives a dummy 0 on the data output at the edge that samples the last address bit. The addressed word then follows, MSB first, one bit per later rising shift-clock edge.
- R7: If clocking continues after the last bit of a word, the next address follows with no further dummy bit. The address wraps from the top location to 0.
- R8: With the organization input high, word w is 16 bits made of byte 2w (upper half) and byte 2w+1 (lower half). With it low, accesses are single bytes.
- R9: An accepted write keeps the block busy for exactly BUSY_CYCLES system clocks. While busy, start bits are ignored.
- R10: If chip select rises while busy, the data output shows 0 until the busy interval ends and 1 after it. Both an accepted start bit and chip select going low remove the status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial shift clock from the host |
| di_i | input | 1 | Serial data input |
| org_i | input | 1 | Organization strap: 1 selects 16-bit words, 0 selects bytes |
| dout_o | output | 1 | Serial data output, also the ready/busy status |

## Verification
Every shift-clock bit takes effect at the first system clock edge that sees the shift clock high. That covers the dummy bit, each read bit and the write strobe. The bench updates its reference model right after that edge and compares the data output at every falling system clock edge. Read data therefore shows up one system clock after the host raises the shift clock. The busy status starts in the same clock as the write strobe and lasts BUSY_CYCLES clocks, and the bench model counts this down in step. The status appears one clock after chip select rises, so the bench leaves out the comparison for that one clock and resumes afterwards.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OP,
    PH_ADDR,
    PH_DATA,
    PH_READ,
    PH_HOLD
  } phase_t;

  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_SPECIAL = 2'b00;

  localparam logic [1:0] SUB_ENABLE  = 2'b11;
  localparam logic [1:0] SUB_DISABLE = 2'b00;

endpackage

// File: rtl/eep_edges.sv
`timescale 1ns/1ps
module eep_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sk_i,
  input  logic cs_i,
  output logic sk_rise_o,
  output logic cs_rise_o
);

  logic sk_q;
  logic cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk_i;
      cs_q <= cs_i;
    end
  end

  assign sk_rise_o = sk_i & ~sk_q;
  assign cs_rise_o = cs_i & ~cs_q;

endmodule

// File: rtl/eep_busy_timer.sv
`timescale 1ns/1ps
module eep_busy_timer #(
  parameter int CYCLES = 1000,
  parameter int CW     = $clog2(CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic [CW-1:0] count_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= CW'(CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign count_o = cnt_q;

endmodule

// File: rtl/eep_array.sv
`timescale 1ns/1ps
module eep_array #(
  parameter int NBYTES = 512,
  parameter int AB     = $clog2(NBYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          org_i,
  input  logic [AB-1:0] addr_i,
  input  logic          we_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o
);

  logic [7:0]    mem_q [NBYTES];
  logic [AB-1:0] hi_idx;
  logic [AB-1:0] lo_idx;

  assign hi_idx = {addr_i[AB-2:0], 1'b0};
  assign lo_idx = {addr_i[AB-2:0], 1'b1};

  always_comb begin
    if (org_i) rdata_o = {mem_q[hi_idx], mem_q[lo_idx]};
    else       rdata_o = {8'h00, mem_q[addr_i]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBYTES; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      if (org_i) begin
        mem_q[hi_idx] <= wdata_i[15:8];
        mem_q[lo_idx] <= wdata_i[7:0];
      end else begin
        mem_q[addr_i] <= wdata_i[7:0];
      end
    end
  end

endmodule

// File: rtl/eep_ctrl.sv
`timescale 1ns/1ps
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int AB = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sk_rise_i,
  input  logic          cs_rise_i,
  input  logic          di_i,
  input  logic          org_i,
  input  logic          busy_i,
  input  logic [15:0]   rdata_i,
  output logic [AB-1:0] addr_o,
  output logic          we_o,
  output logic [15:0]   wdata_o,
  output logic          dout_o,
  output phase_t        phase_o,
  output logic          stat_o
);

  phase_t        phase_q;
  logic [4:0]    cnt_q;
  logic [1:0]    op_q;
  logic [AB-1:0] addr_q;
  logic [15:0]   sh_q;
  logic [16:0]   out_sh_q;
  logic [4:0]    outcnt_q;
  logic          pend_q;
  logic          en_q;
  logic          stat_q;

  logic [4:0]    wlen;
  logic [4:0]    alen;
  logic [AB-1:0] addr_nx;
  logic [AB-1:0] addr_inc;
  logic [15:0]   rd_al;
  logic [1:0]    sub_code;
  logic          addr_last;
  logic          data_last;

  assign wlen      = org_i ? 5'd16 : 5'd8;
  assign alen      = org_i ? 5'(AB - 1) : 5'(AB);
  assign addr_nx   = {addr_q[AB-2:0], di_i};
  assign addr_inc  = org_i ? {1'b0, addr_q[AB-2:0] + 1'b1} : addr_q + 1'b1;
  assign rd_al     = org_i ? rdata_i : {rdata_i[7:0], 8'h00};
  assign sub_code  = org_i ? addr_nx[AB-2:AB-3] : addr_nx[AB-1:AB-2];
  assign addr_last = (cnt_q == alen - 5'd1);
  assign data_last = (cnt_q == wlen - 5'd1);

  assign we_o    = cs_i && sk_rise_i && (phase_q == PH_DATA) && data_last && en_q;
  assign wdata_o = {sh_q[14:0], di_i};
  assign addr_o  = addr_q;
  assign phase_o = phase_q;
  assign stat_o  = stat_q;

  always_comb begin
    if (!cs_i)                    dout_o = 1'b1;
    else if (phase_q == PH_READ)  dout_o = out_sh_q[16];
    else if (stat_q)              dout_o = ~busy_i;
    else                          dout_o = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      op_q     <= '0;
      addr_q   <= '0;
      sh_q     <= '0;
      out_sh_q <= '0;
      outcnt_q <= '0;
      pend_q   <= 1'b0;
      en_q     <= 1'b0;
      stat_q   <= 1'b0;
    end else if (!cs_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      if (cs_rise_i) stat_q <= busy_i;
      if (pend_q) begin
        out_sh_q[15:0] <= rd_al;
        addr_q         <= addr_inc;
        pend_q         <= 1'b0;
      end
      if (sk_rise_i) begin
        unique case (phase_q)
          PH_IDLE: begin
            if (di_i && !busy_i) begin
              phase_q <= PH_OP;
              cnt_q   <= '0;
              stat_q  <= 1'b0;
            end
          end
          PH_OP: begin
            op_q <= {op_q[0], di_i};
            if (cnt_q == 5'd1) begin
              phase_q <= PH_ADDR;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 5'd1;
            end
          end
          PH_ADDR: begin
            addr_q <= addr_nx;
            if (addr_last) begin
              cnt_q <= '0;
              case (op_q)
                OP_READ: begin
                  phase_q  <= PH_READ;
                  out_sh_q <= '0;
                  outcnt_q <= wlen;
                  pend_q   <= 1'b1;
                end
                OP_WRITE: phase_q <= PH_DATA;
                OP_SPECIAL: begin
                  phase_q <= PH_HOLD;
                  if (sub_code == SUB_ENABLE)  en_q <= 1'b1;
                  if (sub_code == SUB_DISABLE) en_q <= 1'b0;
                end
                default: phase_q <= PH_HOLD;
              endcase
            end else begin
              cnt_q <= cnt_q + 5'd1;
            end
          end
          PH_DATA: begin
            sh_q <= {sh_q[14:0], di_i};
            if (data_last) phase_q <= PH_HOLD;
            else           cnt_q   <= cnt_q + 5'd1;
          end
          PH_READ: begin
            if (outcnt_q != '0) begin
              out_sh_q <= {out_sh_q[15:0], 1'b0};
              outcnt_q <= outcnt_q - 5'd1;
            end else begin
              out_sh_q <= {rd_al, 1'b0};
              outcnt_q <= wlen - 5'd1;
              addr_q   <= addr_inc;
            end
          end
          PH_HOLD: ;
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/eep_serial_dev.sv
`timescale 1ns/1ps
module eep_serial_dev
  import eep_pkg::*;
#(
  parameter int MEM_BITS    = 4096,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org_i,
  output logic dout_o
);

  localparam int NBYTES = MEM_BITS / 8;
  localparam int AB     = $clog2(NBYTES);
  localparam int TMR_W  = $clog2(BUSY_CYCLES + 1);

  logic             sk_rise_w;
  logic             cs_rise_w;
  logic             busy_w;
  logic             we_w;
  logic             stat_w;
  logic [AB-1:0]    addr_w;
  logic [15:0]      wdata_w;
  logic [15:0]      rdata_w;
  logic [TMR_W-1:0] cnt_w;
  phase_t           phase_w;

  eep_edges u_edges (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sk_i      (sk_i),
    .cs_i      (cs_i),
    .sk_rise_o (sk_rise_w),
    .cs_rise_o (cs_rise_w)
  );

  eep_ctrl #(.AB(AB)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_i),
    .sk_rise_i (sk_rise_w),
    .cs_rise_i (cs_rise_w),
    .di_i      (di_i),
    .org_i     (org_i),
    .busy_i    (busy_w),
    .rdata_i   (rdata_w),
    .addr_o    (addr_w),
    .we_o      (we_w),
    .wdata_o   (wdata_w),
    .dout_o    (dout_o),
    .phase_o   (phase_w),
    .stat_o    (stat_w)
  );

  eep_array #(.NBYTES(NBYTES), .AB(AB)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .org_i   (org_i),
    .addr_i  (addr_w),
    .we_i    (we_w),
    .wdata_i (wdata_w),
    .rdata_o (rdata_w)
  );

  eep_busy_timer #(.CYCLES(BUSY_CYCLES), .CW(TMR_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (we_w),
    .busy_o  (busy_w),
    .count_o (cnt_w)
  );

endmodule

// File: rtl/eep_serial_dev_chk.sv
`timescale 1ns/1ps
module eep_serial_dev_chk
  import eep_pkg::*;
#(
  parameter int CW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic          dout_o,
  input logic          busy_i,
  input logic          we_i,
  input logic          stat_i,
  input phase_t        phase_i,
  input logic [CW-1:0] cnt_i
);

  AST_IDLE_PIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |-> dout_o); // R1

  AST_DESELECT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (phase_i == PH_IDLE)); // R1

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && phase_i == PH_IDLE) |=> (phase_i == PH_IDLE)); // R9

  AST_BUSY_COUNTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (cnt_i == CW'($past(cnt_i) - 1'b1))); // R9

  AST_TIMER_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(we_i)); // R5

  AST_READ_DUMMY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_READ && $past(phase_i) != PH_READ) |-> !dout_o); // R6

  AST_BUSY_STATUS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && stat_i && busy_i && phase_i == PH_IDLE) |-> !dout_o); // R10

endmodule

bind eep_serial_dev eep_serial_dev_chk #(.CW(TMR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_i    (cs_i),
  .dout_o  (dout_o),
  .busy_i  (busy_w),
  .we_i    (we_w),
  .stat_i  (stat_w),
  .phase_i (phase_w),
  .cnt_i   (cnt_w)
);

// File: tb/eep_serial_dev_bench.sv
`timescale 1ns/1ps
module eep_serial_dev_bench;

  localparam int MEM_BITS = 4096;
  localparam int BUSY     = 200;
  localparam int NB       = MEM_BITS / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sk = 1'b0;
  logic di = 1'b0;
  logic org = 1'b0;
  logic dout;

  always #2.5 clk = ~clk;

  eep_serial_dev #(.MEM_BITS(MEM_BITS), .BUSY_CYCLES(BUSY)) u_eep_serial_dev (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cs_i   (cs),
    .sk_i   (sk),
    .di_i   (di),
    .org_i  (org),
    .dout_o (dout)
  );

  // behavioural reference model
  logic [7:0] bmem [NB];
  bit    en_m = 1'b0;
  int    busy_left = 0;
  bit    shown = 1'b0;
  bit    rd_active = 1'b0;
  bit    rd_bit = 1'b0;
  bit    exp_valid = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    nchecks = 0;
  int    nfail = 0;

  task automatic check(bit ok, string req, int act, int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) if (busy_left > 0) busy_left--;

  always @(negedge clk) begin
    if (rst_n && exp_valid && !done) begin
      logic e;
      if (!cs)            e = 1'b1;
      else if (rd_active) e = rd_bit;
      else if (shown)     e = (busy_left == 0);
      else                e = 1'b1;
      check(dout === e, cur_req, int'(dout), int'(e));
    end
  end

  function automatic int model_read(int a, bit x16);
    if (x16) return {bmem[2*a], bmem[2*a+1]};
    return int'(bmem[a]);
  endfunction

  task automatic tick_sk(bit d);
    di = d;
    sk = 1'b0;
    @(posedge clk); #1;
    sk = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic cs_up();
    bit nxt;
    @(posedge clk); #1;
    exp_valid = 1'b0;
    sk = 1'b0;
    cs = 1'b1;
    nxt = (busy_left > 0);
    @(posedge clk); #1;
    shown = nxt;
    exp_valid = 1'b1;
  endtask

  task automatic cs_down();
    @(posedge clk); #1;
    cs = 1'b0;
    sk = 1'b0;
    rd_active = 1'b0;
    shown = 1'b0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    while (busy_left > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic frame(bit [1:0] op, int addr, int data, int nwords, bit x16, int nlead);
    int aw = x16 ? 8 : 9;
    int w  = x16 ? 16 : 8;
    int wrap = x16 ? NB / 2 : NB;
    bit acc = (busy_left == 0);
    for (int i = 0; i < nlead; i++) tick_sk(1'b0);
    tick_sk(1'b1);
    if (acc) shown = 1'b0;
    tick_sk(op[1]);
    tick_sk(op[0]);
    for (int i = aw - 1; i >= 0; i--) tick_sk(addr[i]);
    if (acc) begin
      if (op == 2'b10) begin
        rd_active = 1'b1;
        rd_bit = 1'b0;
      end else if (op == 2'b00) begin
        int sub = (addr >> (aw - 2)) & 3;
        if (sub == 3) en_m = 1'b1;
        if (sub == 0) en_m = 1'b0;
      end
    end
    if (op == 2'b01) begin
      for (int i = w - 1; i >= 0; i--) tick_sk(data[i]);
      if (acc && en_m) begin
        if (x16) begin
          bmem[2*addr]   = data[15:8];
          bmem[2*addr+1] = data[7:0];
        end else begin
          bmem[addr] = data[7:0];
        end
        busy_left = BUSY;
      end
    end
    if (op == 2'b10) begin
      int a = addr;
      for (int k = 0; k < nwords; k++) begin
        int word = model_read(a, x16);
        for (int i = w - 1; i >= 0; i--) begin
          tick_sk(1'b0);
          if (acc) rd_bit = word[i];
        end
        a = (a + 1) % wrap;
      end
    end
  endtask

  task automatic do_write(int addr, int data, bit x16);
    cs_up();
    frame(2'b01, addr, data, 0, x16, 0);
    cs_down();
    wait_idle();
  endtask

  task automatic do_read(int addr, int nwords, bit x16);
    cs_up();
    frame(2'b10, addr, 0, nwords, x16, 0);
    cs_down();
  endtask

  initial begin
    for (int i = 0; i < NB; i++) bmem[i] = 8'h00;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(dout === 1'b1, "R1 reset idle high", int'(dout), 1);
    exp_valid = 1'b1;

    // R4: write refused while disabled (power-up state, R3)
    cur_req = "R4";
    do_write(5, 'hA5, 1'b0);
    do_read(5, 1, 1'b0);

    // R3: enable writes (top two of 9 address bits = 11)
    cur_req = "R3";
    cs_up(); frame(2'b00, 9'h180, 0, 0, 1'b0, 0); cs_down();

    // R5 and R10: accepted write, busy then ready status
    cur_req = "R5";
    cs_up(); frame(2'b01, 5, 'hA5, 0, 1'b0, 0); cs_down();
    cur_req = "R10";
    cs_up();
    @(negedge clk);
    check(dout === 1'b0, "R10 busy status", int'(dout), 0);
    wait_idle();
    @(negedge clk);
    check(dout === 1'b1, "R10 ready status", int'(dout), 1);
    cs_down();

    // R6: read with dummy bit
    cur_req = "R6";
    do_read(5, 1, 1'b0);

    // R7: sequential read over several bytes
    cur_req = "R7";
    do_write(6, 'h3C, 1'b0);
    do_read(5, 3, 1'b0);

    // R2: leading zeros and the ninth address bit in byte mode
    cur_req = "R2";
    cs_up(); frame(2'b01, 'h1F0, 'h5A, 0, 1'b0, 3); cs_down(); wait_idle();
    cs_up(); frame(2'b10, 'h1F0, 0, 1, 1'b0, 2); cs_down();
    do_read('h0F0, 1, 1'b0);

    // R8: word organization maps onto byte pairs
    cur_req = "R8";
    org = 1'b1;
    do_write(3, 'h1234, 1'b1);
    do_read(2, 2, 1'b1);
    org = 1'b0;
    do_read(6, 2, 1'b0);

    // R7: wrap from top word to word 0
    cur_req = "R7";
    org = 1'b1;
    do_write(255, 'hBEEF, 1'b1);
    do_read(255, 2, 1'b1);
    org = 1'b0;

    // R9: instruction while busy is ignored
    cur_req = "R9";
    cs_up(); frame(2'b01, 10, 'h77, 0, 1'b0, 0); cs_down();
    cs_up();
    frame(2'b10, 5, 0, 1, 1'b0, 0);
    check(dout === 1'b0, "R9 read ignored while busy", int'(dout), 0);
    cs_down();
    wait_idle();
    do_read(10, 1, 1'b0);

    // R3 disable then R4 refused write leaves data
    cur_req = "R3";
    cs_up(); frame(2'b00, 9'h000, 0, 0, 1'b0, 0); cs_down();
    cur_req = "R4";
    do_write(5, 'hFF, 1'b0);
    do_read(5, 1, 1'b0);

    // R1: deselect in the middle of a read drops it
    cur_req = "R1";
    cs_up(); frame(2'b10, 6, 0, 0, 1'b0, 0);
    tick_sk(1'b0);
    cs_down();
    @(negedge clk);
    check(dout === 1'b1, "R1 deselect high", int'(dout), 1);
    do_read(6, 1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchecks++;
      nfail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
      $finish;
    end
  end

endmodule